// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a segment-relative memory access into a 32-bit linear address. It keeps a table of eight segment descriptors and four segment registers. Each descriptor holds a base address, a limit and a present flag. Each segment register holds the index of one descriptor. The four registers are numbered 0 (code), 1 (stack), 2 (data) and 3 (extra). An access names one segment register and carries a 32-bit offset. The block answers one cycle later with either a linear address or a fault code.

Limits are written in compact form: a 20-bit count plus a granularity bit. The block expands this form once, when the descriptor is written. It also works out, at that moment, whether base plus expanded limit would pass the top of the 4 GB linear space. A descriptor that would pass it is kept, but marked as out of range, and it never produces an address. Two descriptors may map onto the same linear bytes, so different segments can alias one another. The usual flat setup places every segment on a single descriptor with base zero and the largest limit.

Descriptor writes and segment register loads each use their own single-cycle write strobe. Requests use a valid/ready handshake, and the registered result is held until the consumer takes it.

Top module: `segxl_translate`

## Requirements
- R1: After synchronous reset, rsp_valid is low and req_ready is high. Every descriptor is marked not present and every segment register selects index 0, so the first access returns fault 1.
- R2: When the granularity bit is 0, the effective limit is the 20-bit count zero-extended to 32 bits.
- R3: When the granularity bit is 1, the effective limit is the count shifted left by 12 with the low 12 bits set to one.
- R4: An offset equal to the effective limit is accepted. An offset one above the limit returns fault 2.
- R5: With no fault, rsp_linear equals the descriptor base plus the offset.
- R6: If base plus effective limit, computed in 33 bits, exceeds 0xFFFFFFFF, every access through that descriptor returns fault 3. A sum of exactly 0xFFFFFFFF is legal.
- R7: Fault codes are 0 none, 1 descriptor not present, 2 limit exceeded, 3 range overflow. When several faults apply, the lowest non-zero code is reported.
- R8: Whenever rsp_fault is non-zero, rsp_linear is zero.
- R9: req_ready equals (not rsp_valid) or rsp_ready. A request accepted at a clock edge has its result on rsp_valid/rsp_linear/rsp_fault after that same edge. While rsp_ready is low, the result stays unchanged.
- R10: A segment register load (register id 0..3, descriptor index 0..7) steers later accesses on that register. Overlapping descriptors alias: two segments reach the same linear address.
- R11: When all four segment registers select one descriptor with base 0 and limit 0xFFFFFFFF, every register maps a given offset to the same linear address.
- R12: Rewriting a descriptor changes the result of the next access through it. Writing it with present=0 makes later accesses return fault 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | 3 | Descriptor index to write |
| desc_base | input | 32 | Base address to write |
| desc_lim_raw | input | 20 | Encoded limit count |
| desc_scale | input | 1 | Granularity bit (1 = 4 KB units) |
| desc_present | input | 1 | Present flag to write |
| sreg_we | input | 1 | Segment register load strobe |
| sreg_id | input | 2 | Segment register to load (0 code, 1 stack, 2 data, 3 extra) |
| sreg_sel | input | 3 | Descriptor index loaded into the register |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_seg | input | 2 | Segment register used by the access |
| req_offset | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_linear | output | 32 | Linear address (zero on fault) |
| rsp_fault | output | 2 | Fault code |

## Verification
A request accepted at a clock edge produces its result after that same edge. The bench drives each request at a falling edge and checks the result at the next falling edge, one full cycle later. Descriptor writes and register loads also take effect at the next edge, so the bench issues each one a cycle before the access that depends on it. When the consumer stalls, the bench keeps a second request waiting and samples on two falling edges. It expects the old result to stay unchanged through the stall and the waiting request to appear one cycle after rsp_ready rises.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    localparam int ADDR_W   = 32;
    localparam int LIM_W    = 20;
    localparam int GRAN_SH  = ADDR_W - LIM_W;
    localparam int NUM_DESC = 8;
    localparam int NUM_SREG = 4;
    localparam int IDX_W    = $clog2(NUM_DESC);
    localparam int SREG_W   = $clog2(NUM_SREG);

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_SPAN   = 2'd3
    } fault_e;

    typedef struct packed {
        logic              present;
        logic              span_bad;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } desc_t;

    typedef struct packed {
        fault_e            fault;
        logic [ADDR_W-1:0] linear;
    } result_t;

    // Expand the compact limit encoding to a full-width byte limit.
    function automatic logic [ADDR_W-1:0] expand_limit(
        input logic [LIM_W-1:0] raw,
        input logic             gran
    );
        logic [ADDR_W-1:0] lim;
        if (gran)
            lim = {raw, {GRAN_SH{1'b1}}};
        else
            lim = {{GRAN_SH{1'b0}}, raw};
        return lim;
    endfunction

    // True when the last byte of the segment lies beyond the linear space.
    function automatic logic span_overflows(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] lim
    );
        logic [ADDR_W:0] sum;
        sum = {1'b0, base} + {1'b0, lim};
        return sum[ADDR_W];
    endfunction

endpackage

// File: rtl/segxl_desc_table.sv
module segxl_desc_table
    import segxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_lim_raw,
    input  logic              wr_gran,
    input  logic              wr_present,
    input  logic [IDX_W-1:0]  rd_idx,
    output desc_t             rd_desc
);

    desc_t             entry [NUM_DESC];
    desc_t             incoming;
    logic [ADDR_W-1:0] new_lim;

    always_comb begin
        new_lim           = expand_limit(wr_lim_raw, wr_gran);
        incoming.present  = wr_present;
        incoming.base     = wr_base;
        incoming.limit    = new_lim;
        incoming.span_bad = span_overflows(wr_base, new_lim);
    end

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                entry[g] <= incoming;
        end
    end

    assign rd_desc = entry[rd_idx];

endmodule

// File: rtl/segxl_sreg_bank.sv
module segxl_sreg_bank
    import segxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [SREG_W-1:0] ld_id,
    input  logic [IDX_W-1:0]  ld_sel,
    input  logic [SREG_W-1:0] rd_id,
    output logic [IDX_W-1:0]  rd_sel
);

    logic [IDX_W-1:0] sel_q [NUM_SREG];

    for (genvar g = 0; g < NUM_SREG; g++) begin : g_sreg
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[g] <= '0;
            else if (ld_en && ld_id == SREG_W'(g))
                sel_q[g] <= ld_sel;
        end
    end

    assign rd_sel = sel_q[rd_id];

endmodule

// File: rtl/segxl_check.sv
module segxl_check
    import segxl_pkg::*;
(
    input  desc_t             desc,
    input  logic [ADDR_W-1:0] offset,
    output result_t           res
);

    logic [ADDR_W-1:0] sum;
    logic              over_limit;

    always_comb begin
        sum        = desc.base + offset;
        over_limit = offset > desc.limit;
        if (!desc.present)
            res.fault = FLT_ABSENT;
        else if (over_limit)
            res.fault = FLT_LIMIT;
        else if (desc.span_bad)
            res.fault = FLT_SPAN;
        else
            res.fault = FLT_NONE;
        res.linear = (res.fault == FLT_NONE) ? sum : '0;
    end

endmodule

// File: rtl/segxl_translate.sv
module segxl_translate
    import segxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_we,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [LIM_W-1:0]  desc_lim_raw,
    input  logic              desc_scale,
    input  logic              desc_present,
    input  logic              sreg_we,
    input  logic [SREG_W-1:0] sreg_id,
    input  logic [IDX_W-1:0]  sreg_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SREG_W-1:0] req_seg,
    input  logic [ADDR_W-1:0] req_offset,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_linear,
    output logic [1:0]        rsp_fault
);

    logic [IDX_W-1:0] cur_sel;
    desc_t            cur_desc;
    result_t          comb_res;
    result_t          res_q;
    logic             valid_q;
    logic             accept;

    segxl_sreg_bank u_sregs (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (sreg_we),
        .ld_id  (sreg_id),
        .ld_sel (sreg_sel),
        .rd_id  (req_seg),
        .rd_sel (cur_sel)
    );

    segxl_desc_table u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (desc_we),
        .wr_idx     (desc_idx),
        .wr_base    (desc_base),
        .wr_lim_raw (desc_lim_raw),
        .wr_gran    (desc_scale),
        .wr_present (desc_present),
        .rd_idx     (cur_sel),
        .rd_desc    (cur_desc)
    );

    segxl_check u_check (
        .desc   (cur_desc),
        .offset (req_offset),
        .res    (comb_res)
    );

    assign req_ready = !valid_q || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= 1'b0;
            res_q.fault  <= FLT_NONE;
            res_q.linear <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            res_q   <= comb_res;
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_linear = res_q.linear;
    assign rsp_fault  = res_q.fault;

endmodule

// File: rtl/segxl_checker.sv
module segxl_checker
    import segxl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_offset,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_linear,
    input logic [1:0]        rsp_fault
);

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !rsp_valid);

    p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_linear == '0);

    p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> req_ready);

    p_result_follows_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_linear) && $stable(rsp_fault)));

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (rsp_fault != 2'd0 || rsp_linear >= $past(req_offset)));

endmodule

bind segxl_translate segxl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_offset (req_offset),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_linear (rsp_linear),
    .rsp_fault  (rsp_fault)
);

// File: tb/segxl_translate_tb.sv
module segxl_translate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_we = 1'b0;
    logic [2:0]  desc_idx = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_lim_raw = '0;
    logic        desc_scale = 1'b0;
    logic        desc_present = 1'b0;
    logic        sreg_we = 1'b0;
    logic [1:0]  sreg_id = '0;
    logic [2:0]  sreg_sel = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_seg = '0;
    logic [31:0] req_offset = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_linear;
    logic [1:0]  rsp_fault;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    segxl_translate u_dut (
        .clk          (clk),
        .rst          (rst),
        .desc_we      (desc_we),
        .desc_idx     (desc_idx),
        .desc_base    (desc_base),
        .desc_lim_raw (desc_lim_raw),
        .desc_scale   (desc_scale),
        .desc_present (desc_present),
        .sreg_we      (sreg_we),
        .sreg_id      (sreg_id),
        .sreg_sel     (sreg_sel),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_seg      (req_seg),
        .req_offset   (req_offset),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_linear   (rsp_linear),
        .rsp_fault    (rsp_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_desc(input logic [2:0] idx, input logic [31:0] base,
                           input logic [19:0] lim, input logic gran, input logic pres);
        @(negedge clk);
        desc_we = 1'b1; desc_idx = idx; desc_base = base;
        desc_lim_raw = lim; desc_scale = gran; desc_present = pres;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic ld_sreg(input logic [1:0] id, input logic [2:0] sel);
        @(negedge clk);
        sreg_we = 1'b1; sreg_id = id; sreg_sel = sel;
        @(negedge clk);
        sreg_we = 1'b0;
    endtask

    // Result is due one cycle after the request is driven.
    task automatic access(input logic [1:0] seg, input logic [31:0] off,
                          input logic [1:0] ef, input logic [31:0] el, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(ef));
        chk({tag, " linear"}, rsp_linear, el);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R1 req_ready in reset", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        access(2'd0, 32'h0, 2'd1, 32'h0, "R1 access via reset table");
    endtask

    task automatic t_basic();
        wr_desc(3'd1, 32'h0000_1000, 20'h000FF, 1'b0, 1'b1);
        ld_sreg(2'd2, 3'd1);
        access(2'd2, 32'h10, 2'd0, 32'h0000_1010, "R5 base plus offset");
        access(2'd2, 32'hFF, 2'd0, 32'h0000_10FF, "R2 R4 offset at limit");
        access(2'd2, 32'h100, 2'd2, 32'h0, "R4 R8 offset above limit");
    endtask

    task automatic t_scale();
        wr_desc(3'd2, 32'h2000_0000, 20'h00003, 1'b1, 1'b1);
        ld_sreg(2'd1, 3'd2);
        access(2'd1, 32'h3FFF, 2'd0, 32'h2000_3FFF, "R3 scaled limit edge");
        access(2'd1, 32'h4000, 2'd2, 32'h0, "R3 scaled limit exceeded");
    endtask

    task automatic t_range();
        wr_desc(3'd3, 32'hFFFF_FFF0, 20'hFFFFF, 1'b1, 1'b1);
        ld_sreg(2'd3, 3'd3);
        access(2'd3, 32'h0, 2'd3, 32'h0, "R6 span past 4GB");
        wr_desc(3'd4, 32'hF000_0000, 20'h0FFFF, 1'b1, 1'b1);
        ld_sreg(2'd3, 3'd4);
        access(2'd3, 32'h0FFF_FFFF, 2'd0, 32'hFFFF_FFFF, "R6 span ends at top");
    endtask

    task automatic t_priority();
        wr_desc(3'd5, 32'hFFFF_0000, 20'h20000, 1'b0, 1'b1);
        ld_sreg(2'd3, 3'd5);
        access(2'd3, 32'h0003_0000, 2'd2, 32'h0, "R7 limit before span");
        access(2'd3, 32'h10, 2'd3, 32'h0, "R7 span fault");
        wr_desc(3'd5, 32'hFFFF_0000, 20'h20000, 1'b0, 1'b0);
        access(2'd3, 32'h0003_0000, 2'd1, 32'h0, "R7 R12 absent first");
    endtask

    task automatic t_alias();
        wr_desc(3'd6, 32'h5000_0000, 20'h1FFFF, 1'b1, 1'b1);
        wr_desc(3'd7, 32'h6000_0000, 20'h7FFFF, 1'b1, 1'b1);
        ld_sreg(2'd0, 3'd6);
        ld_sreg(2'd2, 3'd7);
        access(2'd0, 32'h1000_0000, 2'd0, 32'h6000_0000, "R10 code alias");
        access(2'd2, 32'h0, 2'd0, 32'h6000_0000, "R10 data alias");
        access(2'd0, 32'h2000_0000, 2'd2, 32'h0, "R10 code beyond reach");
    endtask

    task automatic t_flat();
        wr_desc(3'd0, 32'h0, 20'hFFFFF, 1'b1, 1'b1);
        for (int s = 0; s < 4; s++) ld_sreg(2'(s), 3'd0);
        for (int s = 0; s < 4; s++)
            access(2'(s), 32'hDEAD_BEEF, 2'd0, 32'hDEAD_BEEF, "R11 flat identity");
    endtask

    task automatic t_stall();
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_seg = 2'd0; req_offset = 32'h100;
        @(negedge clk);
        req_offset = 32'h200;
        chk("R9 first result valid", 32'(rsp_valid), 32'd1);
        chk("R9 first result addr", rsp_linear, 32'h100);
        chk("R9 not ready while held", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R9 held valid", 32'(rsp_valid), 32'd1);
        chk("R9 held addr", rsp_linear, 32'h100);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 waiting request taken", rsp_linear, 32'h200);
        @(negedge clk);
        chk("R9 drained", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_rewrite();
        ld_sreg(2'd2, 3'd1);
        wr_desc(3'd1, 32'h0000_8000, 20'h000FF, 1'b0, 1'b1);
        access(2'd2, 32'h10, 2'd0, 32'h0000_8010, "R12 rewritten base");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_scale();
                t_range();
                t_priority();
                t_alias();
                t_flat();
                t_stall();
                t_rewrite();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule